// File: doc/BRIEF.md
# Framebuffer Word to Pixel Unpacker

This block sits between the frame-memory fetch path and the pixel pipeline of a display controller. It accepts 32-bit words from frame memory and emits one pixel per cycle. Each word is split according to a 3-bit depth code. The low-depth codes yield palette indices for a separate lookup stage. The high-depth codes yield direct red, green and blue components, each widened to 8 bits.

Two control bits shape how a word is read. One selects whether the first pixel of a word comes from its low end or its high end. The other exchanges the red and blue component positions. The depth code and both control bits are captured together with each word, so the software side may change them at any time: a word is always finished with the settings it arrived with. Both edges use a valid/ready handshake, and a new word can enter in the same cycle that the last pixel of the old word leaves.

Top module: `fb_pixel_unpacker`

## Requirements
- R1: After reset, `pix_valid` is low and `word_ready` is high.
- R2: A word is taken (`word_valid` and `word_ready` both high) only when no pixel is pending, or when the final pixel of the held word leaves in that same cycle. In the second case the first pixel of the new word is presented on the next cycle, with no empty cycle in between.
- R3: While `pix_valid` is high and `pix_ready` is low, every pixel output keeps its value.
- R4: Depth codes 0, 1, 2 and 3 select 1, 2, 4 and 8 bits per pixel, giving 32, 16, 8 and 4 pixels per word. These modes raise `pix_is_index`, place the field zero-extended on `pix_index`, and drive the colour outputs and `pix_intensity` to zero. Colour modes drive `pix_index` to zero.
- R5: With `msb_first` low, pixel k of a word occupies bits [k*w+w-1 : k*w], where w is the pixel width. With `msb_first` high, the first pixel comes from the top of the word.
- R6: Code 4 (16-bit 5551) gives two pixels per word. Within each 16-bit pixel the lowest component is bits 4:0, green is bits 9:5, and the third component is bits 14:10. Bit 15 appears on `pix_intensity` and is not colour.
- R7: Code 6 (16-bit 565) gives two pixels per word. Within each pixel the lowest component is bits 4:0, green is bits 10:5, and the third component is bits 15:11.
- R8: Code 7 (16-bit 444) gives two pixels per word. Within each pixel the lowest component is bits 3:0, green is bits 7:4, and the third component is bits 11:8. Bits 15:12 are ignored.
- R9: Code 5 (24-bit) gives one pixel per word. The lowest component is bits 7:0, green is bits 15:8, and the third component is bits 23:16. Bits 31:24 are ignored.
- R10: With `swap_rb` low, the lowest component is red and the third component is blue. With it high, the lowest component is blue and the third component is red.
- R11: A component narrower than 8 bits is placed in the top bits of its output. The vacated low bits are filled with the component's own most significant bits (4-bit 0xA becomes 0xAA; 5-bit 0x13 becomes 0x9C).
- R12: `mode`, `swap_rb` and `msb_first` are sampled when a word is taken. Changing them while that word is being emitted has no effect on its pixels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| word_valid | input | 1 | Frame word offered |
| word_ready | output | 1 | Frame word can be taken |
| word_data | input | 32 | Frame word |
| mode | input | 3 | Depth / layout code |
| swap_rb | input | 1 | Exchange red and blue positions |
| msb_first | input | 1 | First pixel from the top of the word |
| pix_valid | output | 1 | Pixel presented |
| pix_ready | input | 1 | Pixel taken by the consumer |
| pix_is_index | output | 1 | Pixel is a palette index |
| pix_index | output | 8 | Palette index, zero-extended |
| pix_red | output | 8 | Red component, widened |
| pix_green | output | 8 | Green component, widened |
| pix_blue | output | 8 | Blue component, widened |
| pix_intensity | output | 1 | Top bit of a 5551 pixel |

## Verification
Two functions can fall in the same cycle: the final pixel of a held word leaving, and the next word being taken in. To make this happen, the bench keeps `word_valid` high with the next word and `pix_ready` high through the whole drain. It then checks three things. `word_ready` must be low on pending non-final pixels and high on the final one. The new word's first pixel must appear on the very next cycle. Every pixel of both words must match the values computed from the layout rules. A second overlap, a control change arriving while a word is mid-emission, is provoked by flipping all three controls right after every word is taken.

// File: rtl/pxu_pkg.sv
// pxu_pkg: shared types and helpers for the frame word unpacker.
// Assumes a 32-bit frame word and 8-bit colour channels.
package pxu_pkg;

    localparam int WORD_W = 32;
    localparam int CH_W   = 8;
    localparam int SLOT_W = $clog2(WORD_W);
    localparam int LG_W   = 3;

    // depth / layout codes; the numeric values are the software-visible encoding
    typedef enum logic [2:0] {
        PXM_B1    = 3'd0,
        PXM_B2    = 3'd1,
        PXM_B4    = 3'd2,
        PXM_B8    = 3'd3,
        PXM_P5551 = 3'd4,
        PXM_P888  = 3'd5,
        PXM_P565  = 3'd6,
        PXM_P444  = 3'd7
    } pxm_e;

    // log2 of the storage width of one pixel in the word
    function automatic logic [LG_W-1:0] field_log2(input pxm_e m);
        case (m)
            PXM_B1:   field_log2 = 3'd0;
            PXM_B2:   field_log2 = 3'd1;
            PXM_B4:   field_log2 = 3'd2;
            PXM_B8:   field_log2 = 3'd3;
            PXM_P888: field_log2 = 3'd5;
            default:  field_log2 = 3'd4;
        endcase
    endfunction

    // palette index modes are the four lowest codes
    function automatic logic is_index_mode(input pxm_e m);
        is_index_mode = (m <= PXM_B8);
    endfunction

endpackage

// File: rtl/pxu_word_seq.sv
// pxu_word_seq: holds one frame word with its captured controls and steps
// a slot counter through the pixels it contains.
// Assumes: controls are sampled only when a word is taken; a new word may
// be taken in the cycle the final pixel of the held word is consumed.
module pxu_word_seq
    import pxu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_valid,
    output logic              word_ready,
    input  logic [WORD_W-1:0] word_data,
    input  logic [2:0]        mode_in,
    input  logic              swap_in,
    input  logic              msb_in,
    output logic              pix_valid,
    input  logic              pix_ready,
    output logic [WORD_W-1:0] held_word,
    output pxm_e              held_mode,
    output logic              held_swap,
    output logic              held_msb,
    output logic [SLOT_W-1:0] slot,
    output logic [SLOT_W-1:0] last_slot
);

    logic full;
    logic take_word;
    logic take_pix;
    logic at_last;
    logic [SLOT_W:0] npix;

    // pixel count of the held word, minus one, from its captured mode
    always_comb begin
        npix      = (SLOT_W+1)'(WORD_W) >> field_log2(held_mode);
        last_slot = SLOT_W'(npix - 1'b1);
    end

    // handshake decode on both edges
    always_comb begin
        at_last    = (slot == last_slot);
        pix_valid  = full;
        word_ready = !full || (pix_ready && at_last);
        take_word  = word_valid && word_ready;
        take_pix   = full && pix_ready;
    end

    // word capture and slot stepping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full      <= 1'b0;
            slot      <= '0;
            held_word <= '0;
            held_mode <= PXM_B1;
            held_swap <= 1'b0;
            held_msb  <= 1'b0;
        end else if (take_word) begin
            full      <= 1'b1;
            slot      <= '0;
            held_word <= word_data;
            held_mode <= pxm_e'(mode_in);
            held_swap <= swap_in;
            held_msb  <= msb_in;
        end else if (take_pix) begin
            if (at_last) begin
                full <= 1'b0;
                slot <= '0;
            end else begin
                slot <= slot + 1'b1;
            end
        end
    end

endmodule

// File: rtl/pxu_slice.sv
// pxu_slice: cuts the current pixel field out of the held word and returns
// it right-aligned with all other bits cleared.
// Assumes the field width is 1 << lg and the word holds an integer count.
module pxu_slice
    import pxu_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  logic [LG_W-1:0]   lg,
    input  logic [SLOT_W-1:0] slot,
    input  logic [SLOT_W-1:0] last_slot,
    input  logic              msb_first,
    output logic [WORD_W-1:0] field
);

    localparam int SH_W = SLOT_W + 1;

    logic [SLOT_W-1:0] pos;
    logic [SH_W-1:0]   shift;
    logic [SH_W-1:0]   fw;
    logic [WORD_W-1:0] mask;

    // pick the position in the word from the fetch order
    always_comb begin
        pos   = msb_first ? (last_slot - slot) : slot;
        shift = SH_W'({1'b0, pos} << lg);
        fw    = SH_W'(1) << lg;
        mask  = ~({WORD_W{1'b1}} << fw);
        field = (word >> shift) & mask;
    end

endmodule

// File: rtl/pxu_colour.sv
// pxu_colour: interprets a right-aligned pixel field by mode, producing
// either a palette index or three widened colour channels.
// Assumes the field's unused upper bits are zero.
module pxu_colour
    import pxu_pkg::*;
(
    input  logic [WORD_W-1:0] field,
    input  pxm_e              mode,
    input  logic              swap_rb,
    output logic              is_index,
    output logic [CH_W-1:0]   index,
    output logic [CH_W-1:0]   red,
    output logic [CH_W-1:0]   green,
    output logic [CH_W-1:0]   blue,
    output logic              intensity
);

    localparam int NCH = 3;

    // channel 0 = lowest component, 1 = green, 2 = third component
    logic [CH_W-1:0] ch_top [NCH];
    logic [3:0]      ch_len [NCH];
    logic [CH_W-1:0] ch_wide[NCH];

    // left-align each component and record its width per layout
    always_comb begin
        intensity = 1'b0;
        for (int c = 0; c < NCH; c++) begin
            ch_top[c] = '0;
            ch_len[c] = 4'd8;
        end
        case (mode)
            PXM_P5551: begin
                ch_top[0] = {field[4:0],   3'b0};
                ch_top[1] = {field[9:5],   3'b0};
                ch_top[2] = {field[14:10], 3'b0};
                ch_len[0] = 4'd5;
                ch_len[1] = 4'd5;
                ch_len[2] = 4'd5;
                intensity = field[15];
            end
            PXM_P565: begin
                ch_top[0] = {field[4:0],   3'b0};
                ch_top[1] = {field[10:5],  2'b0};
                ch_top[2] = {field[15:11], 3'b0};
                ch_len[0] = 4'd5;
                ch_len[1] = 4'd6;
                ch_len[2] = 4'd5;
            end
            PXM_P444: begin
                ch_top[0] = {field[3:0],  4'b0};
                ch_top[1] = {field[7:4],  4'b0};
                ch_top[2] = {field[11:8], 4'b0};
                ch_len[0] = 4'd4;
                ch_len[1] = 4'd4;
                ch_len[2] = 4'd4;
            end
            PXM_P888: begin
                ch_top[0] = field[7:0];
                ch_top[1] = field[15:8];
                ch_top[2] = field[23:16];
            end
            default: ;
        endcase
    end

    // widen each channel by folding its top bits into the vacated low bits
    for (genvar c = 0; c < NCH; c++) begin : g_widen
        always_comb begin
            ch_wide[c] = ch_top[c] | (ch_top[c] >> ch_len[c])
                                   | (ch_top[c] >> (ch_len[c] << 1));
        end
    end

    // route channels and the index according to mode and swap
    always_comb begin
        is_index = is_index_mode(mode);
        if (is_index) begin
            index = field[CH_W-1:0];
            red   = '0;
            green = '0;
            blue  = '0;
        end else begin
            index = '0;
            green = ch_wide[1];
            red   = swap_rb ? ch_wide[2] : ch_wide[0];
            blue  = swap_rb ? ch_wide[0] : ch_wide[2];
        end
    end

endmodule

// File: rtl/fb_pixel_unpacker.sv
// fb_pixel_unpacker: frame word in, one pixel per cycle out.
// Assumes a 32-bit word stream and a consumer that may stall at any time;
// palette lookup and timing are handled elsewhere.
module fb_pixel_unpacker
    import pxu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_valid,
    output logic              word_ready,
    input  logic [WORD_W-1:0] word_data,
    input  logic [2:0]        mode,
    input  logic              swap_rb,
    input  logic              msb_first,
    output logic              pix_valid,
    input  logic              pix_ready,
    output logic              pix_is_index,
    output logic [CH_W-1:0]   pix_index,
    output logic [CH_W-1:0]   pix_red,
    output logic [CH_W-1:0]   pix_green,
    output logic [CH_W-1:0]   pix_blue,
    output logic              pix_intensity
);

    logic [WORD_W-1:0] held_word;
    pxm_e              held_mode;
    logic              held_swap;
    logic              held_msb;
    logic [SLOT_W-1:0] slot;
    logic [SLOT_W-1:0] last_slot;
    logic [WORD_W-1:0] field;

    pxu_word_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .word_valid (word_valid),
        .word_ready (word_ready),
        .word_data  (word_data),
        .mode_in    (mode),
        .swap_in    (swap_rb),
        .msb_in     (msb_first),
        .pix_valid  (pix_valid),
        .pix_ready  (pix_ready),
        .held_word  (held_word),
        .held_mode  (held_mode),
        .held_swap  (held_swap),
        .held_msb   (held_msb),
        .slot       (slot),
        .last_slot  (last_slot)
    );

    pxu_slice u_slice (
        .word      (held_word),
        .lg        (field_log2(held_mode)),
        .slot      (slot),
        .last_slot (last_slot),
        .msb_first (held_msb),
        .field     (field)
    );

    pxu_colour u_colour (
        .field     (field),
        .mode      (held_mode),
        .swap_rb   (held_swap),
        .is_index  (pix_is_index),
        .index     (pix_index),
        .red       (pix_red),
        .green     (pix_green),
        .blue      (pix_blue),
        .intensity (pix_intensity)
    );

endmodule

// File: rtl/pxu_checker.sv
// pxu_checker: port-level protocol properties for fb_pixel_unpacker.
module pxu_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       word_valid,
    input logic       word_ready,
    input logic       pix_valid,
    input logic       pix_ready,
    input logic       pix_is_index,
    input logic [7:0] pix_index,
    input logic [7:0] pix_red,
    input logic [7:0] pix_green,
    input logic [7:0] pix_blue,
    input logic       pix_intensity
);

    // R1: reset leaves the output idle and the input open
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (!pix_valid && word_ready));

    // R2: an empty holder always accepts
    a_r2_ready_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid |-> word_ready);

    // R2: a word is never taken over a pixel that is not leaving
    a_r2_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && word_ready && pix_valid) |-> pix_ready);

    // R3: a stalled pixel keeps every output
    a_r3_hold_while_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && !pix_ready) |=> (pix_valid &&
            $stable({pix_is_index, pix_index, pix_red, pix_green, pix_blue, pix_intensity})));

    // R4: index pixels carry no colour or intensity
    a_r4_index_no_colour: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && pix_is_index) |->
            ({pix_red, pix_green, pix_blue} == 24'd0 && !pix_intensity));

    // R4: colour pixels carry no index
    a_r4_colour_no_index: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && !pix_is_index) |-> (pix_index == 8'd0));

endmodule

bind fb_pixel_unpacker pxu_checker u_pxu_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .word_valid    (word_valid),
    .word_ready    (word_ready),
    .pix_valid     (pix_valid),
    .pix_ready     (pix_ready),
    .pix_is_index  (pix_is_index),
    .pix_index     (pix_index),
    .pix_red       (pix_red),
    .pix_green     (pix_green),
    .pix_blue      (pix_blue),
    .pix_intensity (pix_intensity)
);

// File: tb/fb_pixel_unpacker_test.sv
`timescale 1ns/1ps
module fb_pixel_unpacker_test;

    localparam real HALF = 2.5;
    localparam int  WATCHDOG_CYC = 200000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        word_valid = 1'b0;
    logic        word_ready;
    logic [31:0] word_data = '0;
    logic [2:0]  mode = 3'd0;
    logic        swap_rb = 1'b0;
    logic        msb_first = 1'b0;
    logic        pix_valid;
    logic        pix_ready = 1'b0;
    logic        pix_is_index;
    logic [7:0]  pix_index, pix_red, pix_green, pix_blue;
    logic        pix_intensity;

    int n_checks = 0;
    int n_fail   = 0;

    always #HALF clk = ~clk;

    fb_pixel_unpacker uut (
        .clk(clk), .rst_n(rst_n),
        .word_valid(word_valid), .word_ready(word_ready), .word_data(word_data),
        .mode(mode), .swap_rb(swap_rb), .msb_first(msb_first),
        .pix_valid(pix_valid), .pix_ready(pix_ready),
        .pix_is_index(pix_is_index), .pix_index(pix_index),
        .pix_red(pix_red), .pix_green(pix_green), .pix_blue(pix_blue),
        .pix_intensity(pix_intensity)
    );

    // generic check: one count, one FAIL line on mismatch
    task automatic chk(input string req, input logic [33:0] act, input logic [33:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] wid(input logic [7:0] v, input int n);
        logic [7:0] t;
        t = v << (8 - n);
        return t | (t >> n) | (t >> (2 * n));
    endfunction

    // expected {is_index, intensity, index, red, green, blue} from the requirements
    function automatic logic [33:0] model(input logic [31:0] d, input logic [2:0] m,
                                          input logic sw, input logic ord, input int k);
        int w, n, pos;
        logic [31:0] f;
        logic [7:0] c0, g, c2, r, b;
        logic ii, inten;
        w = (m == 3'd0) ? 1 : (m == 3'd1) ? 2 : (m == 3'd2) ? 4 : (m == 3'd3) ? 8 :
            (m == 3'd5) ? 32 : 16;
        n = 32 / w;
        pos = ord ? (n - 1 - k) : k;
        f = (w == 32) ? d : ((d >> (pos * w)) & ((32'd1 << w) - 1));
        ii = (m <= 3'd3);
        inten = 1'b0;
        c0 = 0; g = 0; c2 = 0;
        case (m)
            3'd4: begin c0 = wid(8'(f[4:0]),5); g = wid(8'(f[9:5]),5);
                        c2 = wid(8'(f[14:10]),5); inten = f[15]; end
            3'd6: begin c0 = wid(8'(f[4:0]),5); g = wid(8'(f[10:5]),6);
                        c2 = wid(8'(f[15:11]),5); end
            3'd7: begin c0 = wid(8'(f[3:0]),4); g = wid(8'(f[7:4]),4);
                        c2 = wid(8'(f[11:8]),4); end
            3'd5: begin c0 = f[7:0]; g = f[15:8]; c2 = f[23:16]; end
            default: ;
        endcase
        r = sw ? c2 : c0;
        b = sw ? c0 : c2;
        if (ii) return {1'b1, 1'b0, f[7:0], 24'd0};
        return {1'b0, inten, 8'd0, r, g, b};
    endfunction

    function automatic logic [33:0] outs();
        return {pix_is_index, pix_intensity, pix_index, pix_red, pix_green, pix_blue};
    endfunction

    function automatic int npix(input logic [2:0] m);
        return (m == 3'd0) ? 32 : (m == 3'd1) ? 16 : (m == 3'd2) ? 8 : (m == 3'd3) ? 4 :
               (m == 3'd5) ? 1 : 2;
    endfunction

    // take one word, flip the controls afterwards (R12), drain and check every pixel
    task automatic run_word(input logic [31:0] d, input logic [2:0] m, input logic sw,
                            input logic ord, input string req);
        @(negedge clk);
        word_data = d; mode = m; swap_rb = sw; msb_first = ord;
        word_valid = 1'b1; pix_ready = 1'b0;
        chk({req, " R2 ready while empty"}, 34'(word_ready), 34'd1);
        @(negedge clk);
        word_valid = 1'b0;
        mode = ~m; swap_rb = ~sw; msb_first = ~ord;   // R12: must not matter
        for (int k = 0; k < npix(m); k++) begin
            chk({req, " R12 pixel"}, outs(), model(d, m, sw, ord, k));
            pix_ready = 1'b1;
            @(negedge clk);
        end
        pix_ready = 1'b0;
        chk({req, " R4 word drained"}, 34'(pix_valid), 34'd0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 pix_valid after reset", 34'(pix_valid), 34'd0);
        chk("R1 word_ready after reset", 34'(word_ready), 34'd1);
    endtask

    task automatic t_index_modes();
        run_word(32'hA5C3_0F96, 3'd0, 1'b0, 1'b0, "R4 1bpp lsb");
        run_word(32'h1B2D_E4F0, 3'd1, 1'b0, 1'b1, "R5 2bpp msb");
        run_word(32'h7654_3210, 3'd2, 1'b0, 1'b0, "R4 4bpp lsb");
        run_word(32'h8123_45FE, 3'd3, 1'b1, 1'b1, "R5 8bpp msb");
    endtask

    task automatic t_colour_modes();
        run_word(32'h8421_7C1F, 3'd4, 1'b0, 1'b0, "R6 5551");
        run_word(32'h8421_7C1F, 3'd4, 1'b1, 1'b1, "R10 5551 swap msb");
        run_word(32'hF800_07E0, 3'd6, 1'b0, 1'b0, "R7 565");
        run_word(32'h9B6D_4A52, 3'd6, 1'b1, 1'b0, "R10 565 swap");
        run_word(32'hFABC_0123, 3'd7, 1'b0, 1'b1, "R8 444 msb");
        run_word(32'hFF12_3456, 3'd5, 1'b0, 1'b0, "R9 24bpp");
        run_word(32'h00AB_CDEF, 3'd5, 1'b1, 1'b0, "R10 24bpp swap");
    endtask

    // explicit widening literals: 444 green 0xA -> 0xAA, 565 red 0x13 -> 0x9C
    task automatic t_widen();
        @(negedge clk);
        word_data = 32'h0000_00A0; mode = 3'd7; swap_rb = 1'b0; msb_first = 1'b0;
        word_valid = 1'b1;
        @(negedge clk);
        word_valid = 1'b0;
        chk("R11 444 green 0xA", 34'(pix_green), 34'h0AA);
        pix_ready = 1'b1; repeat (2) @(negedge clk); pix_ready = 1'b0;
        word_data = 32'h0000_0013; mode = 3'd6; word_valid = 1'b1;
        @(negedge clk);
        word_valid = 1'b0;
        chk("R11 565 red 0x13", 34'(pix_red), 34'h09C);
        pix_ready = 1'b1; repeat (2) @(negedge clk); pix_ready = 1'b0;
        chk("R11 drained", 34'(pix_valid), 34'd0);
    endtask

    task automatic t_stall();
        @(negedge clk);
        word_data = 32'h0FED_CBA9; mode = 3'd2; swap_rb = 1'b0; msb_first = 1'b0;
        word_valid = 1'b1; pix_ready = 1'b0;
        @(negedge clk);
        word_valid = 1'b0;
        for (int s = 0; s < 3; s++) begin
            chk("R3 stalled pixel held", outs(), model(32'h0FED_CBA9, 3'd2, 1'b0, 1'b0, 0));
            @(negedge clk);
        end
        chk("R3 still valid", 34'(pix_valid), 34'd1);
        for (int k = 0; k < 8; k++) begin
            chk("R3 after stall", outs(), model(32'h0FED_CBA9, 3'd2, 1'b0, 1'b0, k));
            pix_ready = 1'b1;
            @(negedge clk);
        end
        pix_ready = 1'b0;
    endtask

    // final pixel leaving and next word entering in one cycle
    task automatic t_back_to_back();
        @(negedge clk);
        word_data = 32'h4433_2211; mode = 3'd3; swap_rb = 1'b0; msb_first = 1'b0;
        word_valid = 1'b1; pix_ready = 1'b0;
        @(negedge clk);
        word_data = 32'h8877_6655; mode = 3'd3; msb_first = 1'b1;
        chk("R2 busy while pending", 34'(word_ready), 34'd0);
        pix_ready = 1'b1;
        for (int k = 0; k < 4; k++) begin
            chk("R2 first word", outs(), model(32'h4433_2211, 3'd3, 1'b0, 1'b0, k));
            chk("R2 ready only on final", 34'(word_ready), 34'(k == 3));
            @(negedge clk);
        end
        word_valid = 1'b0;
        chk("R2 no gap", 34'(pix_valid), 34'd1);
        for (int k = 0; k < 4; k++) begin
            chk("R2 second word", outs(), model(32'h8877_6655, 3'd3, 1'b0, 1'b1, k));
            @(negedge clk);
        end
        pix_ready = 1'b0;
        chk("R2 drained", 34'(pix_valid), 34'd0);
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    endtask

    initial begin
        t_reset();
        t_index_modes();
        t_colour_modes();
        t_widen();
        t_stall();
        t_back_to_back();
        summary();
        $finish;
    end

    initial begin
        repeat (WATCHDOG_CYC) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog all requirements actual=hung expected=finished");
        summary();
        $finish;
    end

endmodule